// File: doc/BRIEF.md
# Permission-Checking Translation Buffer

This block is a small, fully associative address translation buffer for loads and stores. A lookup presents a virtual page number, the access type (load or store) and the privilege mode (user or supervisor). The buffer compares the page number against the tag of every entry whose buffer-valid bit is set. On a match it returns the physical page number in the same cycle. It also checks the permission and status bits held in the matching entry and reports at most one exception code.

When a lookup completes without an exception, the buffer marks the entry as used. If the access is a store, it also marks the entry as modified. Both updates take effect on the next clock edge.

Software fills the buffer through a refill port, which writes every field of a chosen slot. The same port reads back, combinationally, the current contents of the slot it addresses. Software can therefore fetch the old entry, including its used and modified bits, before it overwrites it, and write it back to the page table. Page walking and the choice of victim slot are left to software.

Top module: `perm_tlb`

## Requirements
- R1: A lookup whose page number matches no tag among slots with the buffer-valid bit set reports code 1 (miss), with `lk_hit`=0 and `lk_ppn`=0. Tags of slots whose buffer-valid bit is clear are ignored. After reset, every slot has its buffer-valid bit clear.
- R2: A requested lookup that matches a slot drives `lk_hit`=1 and that slot's physical page number on `lk_ppn` in the same cycle.
- R3: A match on a slot whose mapping-valid flag is 0 reports code 2 (invalid). This flag is separate from the buffer-valid bit.
- R4: A user-mode access (`lk_user`=1) to a slot whose supervisor flag is 1 reports code 3 (protection violation). A supervisor-mode access to the same slot is allowed.
- R5: A match on a slot whose resident flag is 0 reports code 4 (page fault).
- R6: A store to a slot whose writable flag is 0 reports code 5 (write fault). A load to the same slot reports code 0.
- R7: When several conditions apply, the lowest code number is reported: miss, then invalid, then protection, then page fault, then write fault.
- R8: A requested lookup that matches and reports code 0 sets the slot's used flag at the next clock edge.
- R9: A store lookup that matches and reports code 0 also sets the slot's modified flag at the next clock edge.
- R10: When any exception is reported, and when `lk_req`=0, no used or modified flag changes.
- R11: Refill writes all fields of slot `rf_idx` at the clock edge when `rf_we`=1. The `rb_*` outputs show the contents of slot `rf_idx` before that edge. If a refill and a status update target the same slot in the same cycle, the refill wins. The flag field bit positions are: bit 0 mapping-valid, bit 1 resident, bit 2 writable, bit 3 used, bit 4 modified, bit 5 supervisor.
- R12: If several valid slots hold the same tag, the lowest-numbered slot supplies the result and receives the status update.
- R13: With `lk_req`=0, `lk_hit`=0 and `lk_exc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| lk_hit | output | 1 | Tag matched a buffer-valid slot |
| lk_ppn | output | PPN_W | Physical page number of the matching slot, 0 otherwise |
| lk_exc | output | 3 | Exception code 0..5 |
| rf_we | input | 1 | Refill write enable |
| rf_idx | input | IDX_W | Slot addressed by refill and readback |
| rf_bvalid | input | 1 | Buffer-valid bit to write |
| rf_vpn | input | VPN_W | Tag to write |
| rf_ppn | input | PPN_W | Physical page number to write |
| rf_flags | input | 6 | Flags to write (positions in R11) |
| rb_bvalid | output | 1 | Buffer-valid bit of slot `rf_idx` |
| rb_vpn | output | VPN_W | Tag of slot `rf_idx` |
| rb_ppn | output | PPN_W | Physical page number of slot `rf_idx` |
| rb_flags | output | 6 | Flags of slot `rf_idx` |

## Verification
A wrong tag or buffer-valid bit appears at once on the next lookup, as a miss where a hit was expected or as a hit where a miss was expected. A wrong flag bit appears in the same cycle as a wrong exception code. A lost or spurious used or modified update changes nothing on the lookup path. It shows only through the readback port, one edge after the access, so the bench reads the slot back after every access that could have changed it. A broken priority between the check conditions appears only when several faults coincide, which is why those combinations are driven on purpose.

// File: rtl/perm_tlb_pkg.sv
package perm_tlb_pkg;

   localparam int FLAG_W = 6;
   localparam int FL_V   = 0;
   localparam int FL_R   = 1;
   localparam int FL_W   = 2;
   localparam int FL_U   = 3;
   localparam int FL_M   = 4;
   localparam int FL_S   = 5;

   typedef enum logic [2:0] {
      EXC_NONE    = 3'd0,
      EXC_MISS    = 3'd1,
      EXC_INVALID = 3'd2,
      EXC_PROT    = 3'd3,
      EXC_PAGE    = 3'd4,
      EXC_WRITE   = 3'd5
   } exc_e;

endpackage

// File: rtl/perm_tlb_entry.sv
module perm_tlb_entry
   import perm_tlb_pkg::*;
#(
   parameter int VPN_W = 32,
   parameter int PPN_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bvalid,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [FLAG_W-1:0] wr_flags,
   input  logic              set_used,
   input  logic              set_mod,
   input  logic [VPN_W-1:0]  look_vpn,
   output logic              out_bvalid,
   output logic [VPN_W-1:0]  out_vpn,
   output logic [PPN_W-1:0]  out_ppn,
   output logic [FLAG_W-1:0] out_flags,
   output logic              match
);

   logic              bvalid_q;
   logic [VPN_W-1:0]  vpn_q;
   logic [PPN_W-1:0]  ppn_q;
   logic [FLAG_W-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         vpn_q    <= '0;
         ppn_q    <= '0;
         flags_q  <= '0;
      end else if (wr_en) begin
         bvalid_q <= wr_bvalid;
         vpn_q    <= wr_vpn;
         ppn_q    <= wr_ppn;
         flags_q  <= wr_flags;
      end else begin
         if (set_used) flags_q[FL_U] <= 1'b1;
         if (set_mod)  flags_q[FL_M] <= 1'b1;
      end
   end

   assign match      = bvalid_q && (vpn_q == look_vpn);
   assign out_bvalid = bvalid_q;
   assign out_vpn    = vpn_q;
   assign out_ppn    = ppn_q;
   assign out_flags  = flags_q;

   AST_USED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_used && !wr_en) |=> flags_q[FL_U]); // R8
   AST_MOD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mod && !wr_en) |=> flags_q[FL_M]); // R9
   AST_UPDATE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      set_used |-> match); // R8

endmodule

// File: rtl/perm_tlb_match.sv
module perm_tlb_match #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] match_vec,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic [ENTRIES-1:0] sel
);

   always_comb begin
      idx = '0;
      sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            idx = IDX_W'(i);
            sel = ENTRIES'(1) << i;
         end
      end
   end

   assign any = |match_vec;

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R12
   AST_SEL_IN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((sel & match_vec) == sel && sel != '0)); // R12
   AST_SEL_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((match_vec & (sel - ENTRIES'(1))) == '0)); // R12

endmodule

// File: rtl/perm_tlb_check.sv
module perm_tlb_check
   import perm_tlb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              any,
   input  logic [FLAG_W-1:0] flags,
   input  logic              store,
   input  logic              user,
   output exc_e              exc
);

   always_comb begin
      if (!req)                         exc = EXC_NONE;
      else if (!any)                    exc = EXC_MISS;
      else if (!flags[FL_V])            exc = EXC_INVALID;
      else if (user && flags[FL_S])     exc = EXC_PROT;
      else if (!flags[FL_R])            exc = EXC_PAGE;
      else if (store && !flags[FL_W])   exc = EXC_WRITE;
      else                              exc = EXC_NONE;
   end

   AST_PROT_USER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (exc == EXC_PROT) |-> user); // R4
   AST_WRITE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (exc == EXC_WRITE) |-> (store && flags[FL_V] && flags[FL_R])); // R7
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      exc <= EXC_WRITE); // R7

endmodule

// File: rtl/perm_tlb.sv
module perm_tlb
   import perm_tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 32,
   parameter int PPN_W   = 28,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic              lk_store,
   input  logic              lk_user,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   output logic [2:0]        lk_exc,
   input  logic              rf_we,
   input  logic [IDX_W-1:0]  rf_idx,
   input  logic              rf_bvalid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [PPN_W-1:0]  rf_ppn,
   input  logic [5:0]        rf_flags,
   output logic              rb_bvalid,
   output logic [VPN_W-1:0]  rb_vpn,
   output logic [PPN_W-1:0]  rb_ppn,
   output logic [5:0]        rb_flags
);

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("perm_tlb: ENTRIES must lie in 2..64");
   end
   if ((1 << IDX_W) != ENTRIES) begin : g_bad_pow2
      $error("perm_tlb: ENTRIES must be a power of two");
   end
   if (VPN_W < 1 || PPN_W < 1) begin : g_bad_width
      $error("perm_tlb: page number widths must be positive");
   end

   logic [ENTRIES-1:0]               match_vec;
   logic [ENTRIES-1:0]               bv_vec;
   logic [ENTRIES-1:0]               sel;
   logic [VPN_W-1:0]                 vpn_arr  [ENTRIES];
   logic [PPN_W-1:0]                 ppn_arr  [ENTRIES];
   logic [ENTRIES-1:0][FLAG_W-1:0]   flags_all;
   logic                             any;
   logic [IDX_W-1:0]                 hit_idx;
   logic [FLAG_W-1:0]                hit_flags;
   exc_e                             exc;
   logic                             clean;

   perm_tlb_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .match_vec (match_vec),
      .any       (any),
      .idx       (hit_idx),
      .sel       (sel)
   );

   assign hit_flags = flags_all[hit_idx];

   perm_tlb_check u_check (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (lk_req),
      .any   (any),
      .flags (hit_flags),
      .store (lk_store),
      .user  (lk_user),
      .exc   (exc)
   );

   assign clean = lk_req && any && (exc == EXC_NONE);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic wr_en_g;
      logic set_used_g;
      assign wr_en_g    = rf_we && (rf_idx == IDX_W'(g));
      assign set_used_g = clean && sel[g];

      perm_tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_entry (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_en      (wr_en_g),
         .wr_bvalid  (rf_bvalid),
         .wr_vpn     (rf_vpn),
         .wr_ppn     (rf_ppn),
         .wr_flags   (rf_flags),
         .set_used   (set_used_g),
         .set_mod    (set_used_g && lk_store),
         .look_vpn   (lk_vpn),
         .out_bvalid (bv_vec[g]),
         .out_vpn    (vpn_arr[g]),
         .out_ppn    (ppn_arr[g]),
         .out_flags  (flags_all[g]),
         .match      (match_vec[g])
      );
   end

   assign lk_hit    = lk_req && any;
   assign lk_ppn    = lk_hit ? ppn_arr[hit_idx] : '0;
   assign lk_exc    = exc;

   assign rb_bvalid = bv_vec[rf_idx];
   assign rb_vpn    = vpn_arr[rf_idx];
   assign rb_ppn    = ppn_arr[rf_idx];
   assign rb_flags  = flags_all[rf_idx];

   AST_NO_UPD_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_req && lk_exc != 3'd0 && !rf_we) |=> $stable(flags_all)); // R10
   AST_NO_UPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_req && !rf_we) |=> $stable(flags_all)); // R10
   AST_MISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_exc == 3'd1) |-> (!lk_hit && lk_ppn == '0)); // R1
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |-> (!lk_hit && lk_exc == 3'd0)); // R13
   AST_HIT_NOT_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_exc != 3'd1)); // R2

endmodule

// File: tb/perm_tlb_test.sv
`timescale 1ns/1ps
module perm_tlb_test;

   localparam int VW = 32;
   localparam int PW = 28;
   localparam logic [5:0] FV = 6'h01, FR = 6'h02, FW = 6'h04,
                          FU = 6'h08, FM = 6'h10, FS = 6'h20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_req = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_store = 1'b0;
   logic          lk_user = 1'b0;
   logic          lk_hit;
   logic [PW-1:0] lk_ppn;
   logic [2:0]    lk_exc;
   logic          rf_we = 1'b0;
   logic [2:0]    rf_idx = '0;
   logic          rf_bvalid = 1'b0;
   logic [VW-1:0] rf_vpn = '0;
   logic [PW-1:0] rf_ppn = '0;
   logic [5:0]    rf_flags = '0;
   logic          rb_bvalid;
   logic [VW-1:0] rb_vpn;
   logic [PW-1:0] rb_ppn;
   logic [5:0]    rb_flags;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   perm_tlb uut (
      .clk(clk), .rst_n(rst_n),
      .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_store(lk_store), .lk_user(lk_user),
      .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_exc(lk_exc),
      .rf_we(rf_we), .rf_idx(rf_idx), .rf_bvalid(rf_bvalid), .rf_vpn(rf_vpn),
      .rf_ppn(rf_ppn), .rf_flags(rf_flags),
      .rb_bvalid(rb_bvalid), .rb_vpn(rb_vpn), .rb_ppn(rb_ppn), .rb_flags(rb_flags)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic refill(input int idx, input logic bv, input logic [VW-1:0] vpn,
                         input logic [PW-1:0] ppn, input logic [5:0] fl);
      @(negedge clk);
      lk_req = 1'b0; rf_we = 1'b1; rf_idx = 3'(idx); rf_bvalid = bv;
      rf_vpn = vpn; rf_ppn = ppn; rf_flags = fl;
      @(negedge clk);
      rf_we = 1'b0;
   endtask

   // drives one lookup, checks the combinational result, leaves one edge for updates
   task automatic access(input string tag, input logic [VW-1:0] vpn, input logic st,
                         input logic usr, input logic ehit, input logic [2:0] eexc,
                         input logic [PW-1:0] eppn);
      @(negedge clk);
      lk_req = 1'b1; lk_vpn = vpn; lk_store = st; lk_user = usr;
      #1;
      chk({tag, " exc"}, 32'(lk_exc), 32'(eexc));
      chk({tag, " hit"}, 32'(lk_hit), 32'(ehit));
      chk({tag, " ppn"}, 32'(lk_ppn), 32'(eppn));
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic rb_flags_is(input string tag, input int idx, input logic [5:0] exp);
      @(negedge clk);
      rf_idx = 3'(idx);
      #1;
      chk(tag, 32'(rb_flags), 32'(exp));
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rf_idx = 3'(i);
         #1;
         chk("R1 reset buffer-valid clear", 32'(rb_bvalid), 32'd0);
      end
      access("R1 lookup after reset", 32'h0, 1'b0, 1'b0, 1'b0, 3'd1, '0);
   endtask

   task automatic t_refill_readback;
      refill(2, 1'b1, 32'h0000_1000, 28'h0ABC, FV|FR|FW);
      @(negedge clk);
      rf_idx = 3'd2;
      #1;
      chk("R11 rb bvalid", 32'(rb_bvalid), 32'd1);
      chk("R11 rb vpn", rb_vpn, 32'h0000_1000);
      chk("R11 rb ppn", 32'(rb_ppn), 32'h0ABC);
      chk("R11 rb flags", 32'(rb_flags), 32'(FV|FR|FW));
      // overwrite: readback shows old contents before the edge, new after
      @(negedge clk);
      rf_we = 1'b1; rf_idx = 3'd2; rf_bvalid = 1'b1; rf_vpn = 32'h0000_1001;
      rf_ppn = 28'h0DEF; rf_flags = FV|FR|FW;
      #1;
      chk("R11 rb old before write", rb_vpn, 32'h0000_1000);
      @(negedge clk);
      rf_we = 1'b0;
      #1;
      chk("R11 rb new after write", rb_vpn, 32'h0000_1001);
      chk("R11 rb new ppn", 32'(rb_ppn), 32'h0DEF);
   endtask

   task automatic t_hit_status;
      access("R2 load hit", 32'h0000_1001, 1'b0, 1'b0, 1'b1, 3'd0, 28'h0DEF);
      rb_flags_is("R8 used set after load", 2, FV|FR|FW|FU);
      access("R2 store hit", 32'h0000_1001, 1'b1, 1'b0, 1'b1, 3'd0, 28'h0DEF);
      rb_flags_is("R9 modified set after store", 2, FV|FR|FW|FU|FM);
   endtask

   task automatic t_bvalid_ignored;
      refill(4, 1'b0, 32'h0000_2000, 28'h0111, FV|FR|FW);
      access("R1 cleared slot ignored", 32'h0000_2000, 1'b0, 1'b0, 1'b0, 3'd1, '0);
   endtask

   task automatic t_faults;
      refill(5, 1'b1, 32'h0000_3000, 28'h0222, FR|FW);
      access("R3 mapping invalid", 32'h0000_3000, 1'b0, 1'b0, 1'b1, 3'd2, 28'h0222);
      rb_flags_is("R10 no update on invalid", 5, FR|FW);
      refill(6, 1'b1, 32'h0000_4000, 28'h0333, FV|FR|FW|FS);
      access("R4 user to supervisor page", 32'h0000_4000, 1'b0, 1'b1, 1'b1, 3'd3, 28'h0333);
      rb_flags_is("R10 no update on protection", 6, FV|FR|FW|FS);
      access("R4 supervisor allowed", 32'h0000_4000, 1'b0, 1'b0, 1'b1, 3'd0, 28'h0333);
      refill(7, 1'b1, 32'h0000_5000, 28'h0444, FV|FW);
      access("R5 not resident", 32'h0000_5000, 1'b1, 1'b0, 1'b1, 3'd4, 28'h0444);
      rb_flags_is("R10 no update on page fault", 7, FV|FW);
      refill(0, 1'b1, 32'h0000_6000, 28'h0555, FV|FR);
      access("R6 store to read-only", 32'h0000_6000, 1'b1, 1'b0, 1'b1, 3'd5, 28'h0555);
      rb_flags_is("R10 no update on write fault", 0, FV|FR);
      access("R6 load to read-only", 32'h0000_6000, 1'b0, 1'b0, 1'b1, 3'd0, 28'h0555);
      rb_flags_is("R8 used only after clean load", 0, FV|FR|FU);
   endtask

   task automatic t_priority;
      refill(1, 1'b1, 32'h0000_7000, 28'h0666, FS);
      access("R7 invalid beats protection", 32'h0000_7000, 1'b1, 1'b1, 1'b1, 3'd2, 28'h0666);
      refill(1, 1'b1, 32'h0000_7000, 28'h0666, FV|FS);
      access("R7 protection beats page fault", 32'h0000_7000, 1'b1, 1'b1, 1'b1, 3'd3, 28'h0666);
      access("R7 page fault beats write fault", 32'h0000_7000, 1'b1, 1'b0, 1'b1, 3'd4, 28'h0666);
      refill(1, 1'b1, 32'h0000_7000, 28'h0666, FV|FR|FS);
      access("R7 write fault last", 32'h0000_7000, 1'b1, 1'b0, 1'b1, 3'd5, 28'h0666);
   endtask

   task automatic t_idle;
      refill(0, 1'b1, 32'h0000_6000, 28'h0555, FV|FR|FW);
      @(negedge clk);
      lk_req = 1'b0; lk_vpn = 32'h0000_6000; lk_store = 1'b1; lk_user = 1'b0;
      #1;
      chk("R13 idle hit low", 32'(lk_hit), 32'd0);
      chk("R13 idle exc zero", 32'(lk_exc), 32'd0);
      rb_flags_is("R10 no update when idle", 0, FV|FR|FW);
   endtask

   task automatic t_duplicate;
      refill(3, 1'b1, 32'h0000_8000, 28'h0777, FV|FR|FW);
      refill(4, 1'b1, 32'h0000_8000, 28'h0888, FV|FR|FW);
      access("R12 lowest slot wins", 32'h0000_8000, 1'b1, 1'b0, 1'b1, 3'd0, 28'h0777);
      rb_flags_is("R12 lower slot updated", 3, FV|FR|FW|FU|FM);
      rb_flags_is("R12 higher slot untouched", 4, FV|FR|FW);
   endtask

   task automatic t_refill_wins;
      @(negedge clk);
      lk_req = 1'b1; lk_vpn = 32'h0000_8000; lk_store = 1'b1; lk_user = 1'b0;
      rf_we = 1'b1; rf_idx = 3'd3; rf_bvalid = 1'b1; rf_vpn = 32'h0000_8000;
      rf_ppn = 28'h0999; rf_flags = FV|FR;
      @(negedge clk);
      lk_req = 1'b0; rf_we = 1'b0;
      #1;
      chk("R11 refill beats status update", 32'(rb_flags), 32'(FV|FR));
      chk("R11 refill ppn", 32'(rb_ppn), 32'h0999);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_refill_readback();
      t_hit_status();
      t_bvalid_ignored();
      t_faults();
      t_priority();
      t_idle();
      t_duplicate();
      t_refill_wins();
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule